// File: doc/BRIEF.md
# Bottleneck Request Scheduler for an Accelerator Core

This block sits next to one fast core in an asymmetric multi-core and holds the bottleneck requests that slow cores send to it. A request names the bottleneck, the program counter to resume at, the stack pointer and the slow core that sent it. All hardware thread contexts of the fast core share the one scheduler. It has one slot for each slow core. A slow core may have only one request held at a time.

An external tracking table supplies each held slot's current waiting-cycle priority and a ready flag. The table reads each slot's bottleneck identifier from the `slot_bid` outputs. The scheduler offers the fast core the ready request with the highest priority. When the fast core takes a request, that is one selection round. A ready request that stays waiting through a programmable number of such rounds is bounced back to its own core to run there, so that independent work is not held behind a busier bottleneck. When the fast core finishes a request, it names the originating core. The slot is released and a done message goes back to that core in the same cycle.

Top module: `bsb_sched_buf`

## Requirements
- R1: An enqueue is accepted (`enq_ok` high) when some slot is free and the sending core holds no slot. The request goes into the lowest-numbered free slot, and that slot's identifier appears on `slot_bid` from the next cycle on.
- R2: `enq_full` is high while every slot is occupied, and no enqueue is accepted then. The sender must retry.
- R3: `enq_dup` is high when the sending core already holds a slot (waiting or running). That enqueue is not stored.
- R4: `iss_valid` offers the waiting, ready slot with the largest `slot_prio` value. Slots whose bounce count has reached a nonzero limit are left out. The offer shows that slot's source core, identifier, PC and SP.
- R5: Among offered candidates with equal priority, the one from the lowest-numbered source core wins, whatever its slot number.
- R6: A slot whose `slot_ready` bit is low is never offered. With no waiting ready slot, `iss_valid` is low.
- R7: A slot taken with `lc_take` is running and is not offered again.
- R8: Each take counts one round for every other waiting, ready slot. A slot whose count has reached a nonzero `bnc_limit` is reported on `bnc_valid` with its source, identifier, PC and SP. That slot is freed at the next edge. The lowest-numbered such slot goes first.
- R9: With `bnc_limit` equal to zero, no bounce happens. Rounds keep counting, and they act once a nonzero limit is set.
- R10: `ret_valid` with the source of a running slot raises `done_valid` with that source in the same cycle and frees the slot at the next edge. A source that holds no running slot gives no done message.
- R11: After reset, every slot is free: `iss_valid`, `bnc_valid`, `done_valid` and `enq_full` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enq_valid | input | 1 | Enqueue request from a slow core |
| enq_src | input | CORE_W | Sending core number |
| enq_bid | input | BID_W | Bottleneck identifier |
| enq_pc | input | PC_W | Resume program counter |
| enq_sp | input | SP_W | Stack pointer |
| enq_ok | output | 1 | Enqueue accepted this cycle |
| enq_full | output | 1 | All slots occupied (backpressure) |
| enq_dup | output | 1 | Sender already holds a slot |
| slot_bid | output | DEPTH*BID_W | Identifier held in each slot, for priority lookup |
| slot_prio | input | DEPTH*PRIO_W | Waiting-cycle priority for each slot |
| slot_ready | input | DEPTH | Ready flag for each slot |
| iss_valid | output | 1 | A request is offered to the fast core |
| iss_slot | output | SLOT_W | Slot of the offered request |
| iss_src | output | CORE_W | Source core of the offered request |
| iss_bid | output | BID_W | Identifier of the offered request |
| iss_pc | output | PC_W | PC of the offered request |
| iss_sp | output | SP_W | SP of the offered request |
| lc_take | input | 1 | Fast core takes the offered request |
| bnc_limit | input | PASS_W | Rounds passed over before bounce; 0 disables |
| bnc_valid | output | 1 | A request is sent back to its core |
| bnc_src | output | CORE_W | Core receiving the bounced request |
| bnc_bid | output | BID_W | Bounced identifier |
| bnc_pc | output | PC_W | Bounced PC |
| bnc_sp | output | SP_W | Bounced SP |
| ret_valid | input | 1 | Fast core finished a request |
| ret_src | input | CORE_W | Source core of the finished request |
| done_valid | output | 1 | Done message to a slow core |
| done_src | output | CORE_W | Core receiving the done message |

## Verification
The selection logic is swept over every combination of four priority levels on three slots and every ready mask. Slots are loaded so that slot order and source order differ, which tells a tie broken by core number from one broken by slot number. It also tells a ready-mask bug from a comparison bug. Take sequences with a limit of two push one slot into a bounce. A later zero-then-one limit shows that rounds are counted while bouncing is switched off. Duplicate, full, completion and reuse patterns check the lowest free slot choice and that a finished slot frees and accepts its core again.

// File: rtl/bsb_pkg.sv
package bsb_pkg;
   typedef enum logic [1:0] {
      SL_FREE = 2'd0,
      SL_WAIT = 2'd1,
      SL_RUN  = 2'd2
   } slot_st_e;
endpackage

// File: rtl/bsb_first_set.sv
module bsb_first_set #(
   parameter int N  = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);
   generate
      if (N == 1) begin : g_one
         assign found = vec[0];
         assign idx   = '0;
      end else begin : g_many
         always_comb begin
            idx = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (vec[i]) idx = IW'(i);
            end
         end
         assign found = |vec;
      end
   endgenerate
endmodule

// File: rtl/bsb_prio_pick.sv
module bsb_prio_pick #(
   parameter int N  = 4,
   parameter int PW = 8,
   parameter int KW = 2,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]    cand,
   input  logic [N*PW-1:0] prio,
   input  logic [N*KW-1:0] key,
   output logic            found,
   output logic [IW-1:0]   idx
);
   generate
      if (N == 1) begin : g_one
         assign found = cand[0];
         assign idx   = '0;
      end else begin : g_many
         logic [PW-1:0] best_p;
         logic [KW-1:0] best_k;
         always_comb begin
            found  = 1'b0;
            idx    = '0;
            best_p = '0;
            best_k = '0;
            for (int i = 0; i < N; i++) begin
               if (cand[i] && (!found || prio[i*PW +: PW] > best_p ||
                   (prio[i*PW +: PW] == best_p && key[i*KW +: KW] < best_k))) begin
                  found  = 1'b1;
                  idx    = IW'(i);
                  best_p = prio[i*PW +: PW];
                  best_k = key[i*KW +: KW];
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/bsb_sched_buf.sv
module bsb_sched_buf
   import bsb_pkg::*;
#(
   parameter int N_CORE = 4,
   parameter int DEPTH  = 4,
   parameter int BID_W  = 8,
   parameter int PC_W   = 16,
   parameter int SP_W   = 16,
   parameter int PRIO_W = 8,
   parameter int PASS_W = 4,
   localparam int CORE_W = (N_CORE > 1) ? $clog2(N_CORE) : 1,
   localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    enq_valid,
   input  logic [CORE_W-1:0]       enq_src,
   input  logic [BID_W-1:0]        enq_bid,
   input  logic [PC_W-1:0]         enq_pc,
   input  logic [SP_W-1:0]         enq_sp,
   output logic                    enq_ok,
   output logic                    enq_full,
   output logic                    enq_dup,
   output logic [DEPTH*BID_W-1:0]  slot_bid,
   input  logic [DEPTH*PRIO_W-1:0] slot_prio,
   input  logic [DEPTH-1:0]        slot_ready,
   output logic                    iss_valid,
   output logic [SLOT_W-1:0]       iss_slot,
   output logic [CORE_W-1:0]       iss_src,
   output logic [BID_W-1:0]        iss_bid,
   output logic [PC_W-1:0]         iss_pc,
   output logic [SP_W-1:0]         iss_sp,
   input  logic                    lc_take,
   input  logic [PASS_W-1:0]       bnc_limit,
   output logic                    bnc_valid,
   output logic [CORE_W-1:0]       bnc_src,
   output logic [BID_W-1:0]        bnc_bid,
   output logic [PC_W-1:0]         bnc_pc,
   output logic [SP_W-1:0]         bnc_sp,
   input  logic                    ret_valid,
   input  logic [CORE_W-1:0]       ret_src,
   output logic                    done_valid,
   output logic [CORE_W-1:0]       done_src
);
   generate
      if (N_CORE < 2)                      begin : g_chk_core  $error("N_CORE must be at least 2"); end
      if (DEPTH < 1 || DEPTH > N_CORE)     begin : g_chk_depth $error("DEPTH must lie in 1..N_CORE"); end
      if (PRIO_W < 1 || PASS_W < 1)        begin : g_chk_width $error("PRIO_W and PASS_W must be positive"); end
   endgenerate

   slot_st_e            st  [DEPTH];
   logic [CORE_W-1:0]   src [DEPTH];
   logic [BID_W-1:0]    bid [DEPTH];
   logic [PC_W-1:0]     pc  [DEPTH];
   logic [SP_W-1:0]     sp  [DEPTH];
   logic [PASS_W-1:0]   cnt [DEPTH];

   logic [DEPTH-1:0]        free_v, wait_v, rdy_w, bnc_elig, cand, dup_v, ret_v;
   logic [DEPTH*CORE_W-1:0] src_flat;
   logic [SLOT_W-1:0]       alloc_idx, bnc_idx, ret_idx;
   logic                    alloc_found, ret_found, take;

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_vec
         assign free_v[g]   = (st[g] == SL_FREE);
         assign wait_v[g]   = (st[g] == SL_WAIT);
         assign rdy_w[g]    = wait_v[g] && slot_ready[g];
         assign bnc_elig[g] = rdy_w[g] && (bnc_limit != '0) && (cnt[g] >= bnc_limit);
         assign cand[g]     = rdy_w[g] && !bnc_elig[g];
         assign dup_v[g]    = !free_v[g] && (src[g] == enq_src);
         assign ret_v[g]    = (st[g] == SL_RUN) && (src[g] == ret_src);
         assign src_flat[g*CORE_W +: CORE_W] = src[g];
         assign slot_bid[g*BID_W +: BID_W]   = bid[g];
      end
   endgenerate

   bsb_first_set #(.N(DEPTH)) u_alloc (.vec(free_v),   .found(alloc_found), .idx(alloc_idx));
   bsb_first_set #(.N(DEPTH)) u_bnc   (.vec(bnc_elig), .found(bnc_valid),   .idx(bnc_idx));
   bsb_first_set #(.N(DEPTH)) u_ret   (.vec(ret_v),    .found(ret_found),   .idx(ret_idx));

   bsb_prio_pick #(.N(DEPTH), .PW(PRIO_W), .KW(CORE_W)) u_pick (
      .cand(cand), .prio(slot_prio), .key(src_flat),
      .found(iss_valid), .idx(iss_slot)
   );

   assign enq_full   = !alloc_found;
   assign enq_dup    = enq_valid && |dup_v;
   assign enq_ok     = enq_valid && alloc_found && !(|dup_v);
   assign take       = lc_take && iss_valid;
   assign done_valid = ret_valid && ret_found;
   assign done_src   = ret_src;

   assign iss_src = src[iss_slot];
   assign iss_bid = bid[iss_slot];
   assign iss_pc  = pc[iss_slot];
   assign iss_sp  = sp[iss_slot];
   assign bnc_src = src[bnc_idx];
   assign bnc_bid = bid[bnc_idx];
   assign bnc_pc  = pc[bnc_idx];
   assign bnc_sp  = sp[bnc_idx];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st[g]  <= SL_FREE;
               cnt[g] <= '0;
            end else if (enq_ok && alloc_idx == SLOT_W'(g)) begin
               st[g]  <= SL_WAIT;
               cnt[g] <= '0;
            end else if (take && iss_slot == SLOT_W'(g)) begin
               st[g]  <= SL_RUN;
            end else if (bnc_valid && bnc_idx == SLOT_W'(g)) begin
               st[g]  <= SL_FREE;
            end else if (done_valid && ret_idx == SLOT_W'(g)) begin
               st[g]  <= SL_FREE;
            end else if (take && rdy_w[g] && cnt[g] != '1) begin
               cnt[g] <= cnt[g] + 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (enq_ok && alloc_idx == SLOT_W'(g)) begin
               src[g] <= enq_src;
               bid[g] <= enq_bid;
               pc[g]  <= enq_pc;
               sp[g]  <= enq_sp;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/bsb_sched_buf_chk.sv
module bsb_sched_buf_chk #(
   parameter int DEPTH  = 4,
   parameter int PRIO_W = 8,
   parameter int PASS_W = 4,
   parameter int CORE_W = 2,
   parameter int SLOT_W = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    enq_ok,
   input logic                    enq_full,
   input logic                    enq_dup,
   input logic [DEPTH*PRIO_W-1:0] slot_prio,
   input logic [DEPTH-1:0]        slot_ready,
   input logic [DEPTH-1:0]        wait_v,
   input logic [DEPTH*CORE_W-1:0] src_flat,
   input logic                    iss_valid,
   input logic [SLOT_W-1:0]       iss_slot,
   input logic [CORE_W-1:0]       iss_src,
   input logic                    lc_take,
   input logic [PASS_W-1:0]       bnc_limit,
   input logic                    bnc_valid,
   input logic [CORE_W-1:0]       bnc_src,
   input logic                    ret_valid,
   input logic                    done_valid
);
   logic                better;
   logic [PRIO_W-1:0]   ip;
   always_comb begin
      better = 1'b0;
      ip     = slot_prio[iss_slot*PRIO_W +: PRIO_W];
      for (int i = 0; i < DEPTH; i++) begin
         if (wait_v[i] && slot_ready[i] && SLOT_W'(i) != iss_slot &&
             (slot_prio[i*PRIO_W +: PRIO_W] > ip ||
              (slot_prio[i*PRIO_W +: PRIO_W] == ip && src_flat[i*CORE_W +: CORE_W] < iss_src)))
            better = 1'b1;
      end
   end

   a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      enq_full |-> !enq_ok);
   a_r3_dup_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      enq_dup |-> !enq_ok);
   // R4 and R5: nothing better waits while bouncing is off
   a_r4_best_offered: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && bnc_limit == '0) |-> !better);
   a_r6_ready_only: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> (slot_ready[iss_slot] && wait_v[iss_slot]));
   a_r7_no_reoffer: assert property (@(posedge clk) disable iff (!rst_n)
      (lc_take && iss_valid) |=> !(iss_valid && iss_slot == $past(iss_slot)));
   a_r8_bounce_not_issued: assert property (@(posedge clk) disable iff (!rst_n)
      (bnc_valid && iss_valid) |-> (bnc_src != iss_src));
   a_r9_limit_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bnc_limit == '0) |-> !bnc_valid);
   a_r10_done_needs_ret: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> ret_valid);
endmodule

bind bsb_sched_buf bsb_sched_buf_chk #(
   .DEPTH(DEPTH), .PRIO_W(PRIO_W), .PASS_W(PASS_W), .CORE_W(CORE_W), .SLOT_W(SLOT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .enq_ok(enq_ok), .enq_full(enq_full), .enq_dup(enq_dup),
   .slot_prio(slot_prio), .slot_ready(slot_ready), .wait_v(wait_v), .src_flat(src_flat),
   .iss_valid(iss_valid), .iss_slot(iss_slot), .iss_src(iss_src), .lc_take(lc_take),
   .bnc_limit(bnc_limit), .bnc_valid(bnc_valid), .bnc_src(bnc_src),
   .ret_valid(ret_valid), .done_valid(done_valid)
);

// File: tb/tb_bsb_sched_buf.sv
module tb_bsb_sched_buf;
   localparam int NC = 4, D = 3, BW = 8, PW = 12, SW = 12, QW = 4, KW = 3;
   localparam int CW = 2, LW = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic enq_valid = 1'b0;
   logic [CW-1:0] enq_src = '0;
   logic [BW-1:0] enq_bid = '0;
   logic [PW-1:0] enq_pc = '0;
   logic [SW-1:0] enq_sp = '0;
   logic enq_ok, enq_full, enq_dup;
   logic [D*BW-1:0] slot_bid;
   logic [D*QW-1:0] slot_prio = '0;
   logic [D-1:0] slot_ready = '0;
   logic iss_valid;
   logic [LW-1:0] iss_slot;
   logic [CW-1:0] iss_src;
   logic [BW-1:0] iss_bid;
   logic [PW-1:0] iss_pc;
   logic [SW-1:0] iss_sp;
   logic lc_take = 1'b0;
   logic [KW-1:0] bnc_limit = '0;
   logic bnc_valid;
   logic [CW-1:0] bnc_src;
   logic [BW-1:0] bnc_bid;
   logic [PW-1:0] bnc_pc;
   logic [SW-1:0] bnc_sp;
   logic ret_valid = 1'b0;
   logic [CW-1:0] ret_src = '0;
   logic done_valid;
   logic [CW-1:0] done_src;

   int n_run = 0, n_fail = 0;

   always #5 clk = ~clk;

   bsb_sched_buf #(.N_CORE(NC), .DEPTH(D), .BID_W(BW), .PC_W(PW), .SP_W(SW),
                   .PRIO_W(QW), .PASS_W(KW)) dut (.*);

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic enq(input int s, input int b, input int exp_ok);
      enq_valid = 1'b1;
      enq_src = CW'(s);
      enq_bid = BW'(b);
      enq_pc = PW'(12'h100 + s);
      enq_sp = SW'(12'h800 + s);
      #1;
      chk("R1 enq_ok", int'(enq_ok), exp_ok);
      cyc();
      enq_valid = 1'b0;
   endtask

   task automatic setp(input int a, input int b, input int c);
      slot_prio = {QW'(c), QW'(b), QW'(a)};
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int srcmap [3];
      srcmap = '{2, 0, 1};
      repeat (2) cyc();
      // R11 reset state
      chk("R11 iss_valid", int'(iss_valid), 0);
      chk("R11 enq_full", int'(enq_full), 0);
      chk("R11 bnc_valid", int'(bnc_valid), 0);
      rst_n = 1'b1;
      cyc();
      chk("R11 done_valid", int'(done_valid), 0);

      // R1 fill: src2 -> slot0, src0 -> slot1, src1 -> slot2
      enq(2, 8'h20, 1);
      enq(0, 8'h10, 1);
      enq(1, 8'h30, 1);
      chk("R1 slot0 bid", int'(slot_bid[7:0]), 8'h20);
      chk("R1 slot1 bid", int'(slot_bid[15:8]), 8'h10);
      chk("R1 slot2 bid", int'(slot_bid[23:16]), 8'h30);

      // R2 full
      enq_valid = 1'b1; enq_src = 2'd3; #1;
      chk("R2 enq_full", int'(enq_full), 1);
      chk("R2 enq_ok", int'(enq_ok), 0);
      enq_valid = 1'b0;
      cyc();

      // R4 R5 R6 sweep with no takes
      for (int p0 = 0; p0 < 4; p0++)
         for (int p1 = 0; p1 < 4; p1++)
            for (int p2 = 0; p2 < 4; p2++)
               for (int m = 0; m < 8; m++) begin
                  int pr [3];
                  int best, bp, bs;
                  pr = '{p0, p1, p2};
                  setp(p0, p1, p2);
                  slot_ready = D'(m);
                  best = -1; bp = 0; bs = 0;
                  for (int i = 0; i < 3; i++)
                     if (m[i] && (best < 0 || pr[i] > bp || (pr[i] == bp && srcmap[i] < bs))) begin
                        best = i; bp = pr[i]; bs = srcmap[i];
                     end
                  #1;
                  if (best < 0) chk("R6 no ready", int'(iss_valid), 0);
                  else begin
                     chk("R4 iss_valid", int'(iss_valid), 1);
                     chk("R5 R4 iss_src", int'(iss_src), bs);
                  end
               end
      cyc();

      // R4, R5, R7, R8 take sequence
      setp(3, 1, 1); slot_ready = 3'b111; bnc_limit = 3'd2; #1;
      chk("R4 top", int'(iss_src), 2);
      chk("R4 pc", int'(iss_pc), 12'h102);
      lc_take = 1'b1; cyc(); lc_take = 1'b0; #1;
      chk("R5 tie", int'(iss_src), 0);
      chk("R7 valid", int'(iss_valid), 1);
      lc_take = 1'b1; cyc(); lc_take = 1'b0; #1;
      chk("R8 bnc_valid", int'(bnc_valid), 1);
      chk("R8 bnc_src", int'(bnc_src), 1);
      chk("R8 bnc_pc", int'(bnc_pc), 12'h101);
      chk("R8 no offer", int'(iss_valid), 0);
      cyc();
      chk("R8 freed", int'(bnc_valid), 0);
      chk("R8 not full", int'(enq_full), 0);

      // R3 duplicate from running src0
      enq_valid = 1'b1; enq_src = 2'd0; #1;
      chk("R3 enq_dup", int'(enq_dup), 1);
      chk("R3 enq_ok", int'(enq_ok), 0);
      enq_valid = 1'b0;
      cyc();

      // R10 completion
      ret_valid = 1'b1; ret_src = 2'd2; #1;
      chk("R10 done_valid", int'(done_valid), 1);
      chk("R10 done_src", int'(done_src), 2);
      cyc(); ret_valid = 1'b0;
      enq(3, 8'h40, 1);
      chk("R1 lowest free", int'(slot_bid[7:0]), 8'h40);
      enq(2, 8'h50, 1);
      chk("R10 reuse", int'(slot_bid[23:16]), 8'h50);
      ret_valid = 1'b1; ret_src = 2'd1; #1;
      chk("R10 no match", int'(done_valid), 0);
      cyc(); ret_valid = 1'b0;

      // R6 then R9
      slot_ready = 3'b000; bnc_limit = 3'd0; #1;
      chk("R6 none ready", int'(iss_valid), 0);
      setp(1, 0, 3); slot_ready = 3'b101; #1;
      chk("R4 slot2", int'(iss_src), 2);
      lc_take = 1'b1; cyc(); lc_take = 1'b0; #1;
      chk("R9 no bounce", int'(bnc_valid), 0);
      chk("R9 still offered", int'(iss_src), 3);
      bnc_limit = 3'd1; #1;
      chk("R9 count kept", int'(bnc_valid), 1);
      chk("R8 bnc_src", int'(bnc_src), 3);
      cyc();

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule